// File: doc/BRIEF.md
# Address-Triggered Load/Store Register Unit

This block holds the architectural register state of a load/store machine with three banks: eight 60-bit data registers, eight 18-bit address registers and eight 18-bit index registers. It accepts one instruction word per handshake. The word is either a short three-register form, used for data and index add/subtract, or a long form that adds an 18-bit displacement to a register. The block decodes the word, performs the add or subtract, writes the result back, and reports each write one cycle later on a write-back port.

There are no load or store opcodes. Memory traffic happens only as a side effect of writing an address register. The index of the address register picks both the direction and the paired data register:

- Indices 1 to 5 start a read. The response later fills the data register with the same index.
- Indices 6 and 7 start a write of the same-index data register.
- Index 0 starts nothing.

A per-register pending flag marks each data register that is waiting for a read. Any instruction that touches such a register, or rewrites its address register, is held off at the instruction input.

A small controller with two states governs the memory request:

- **ST_OPEN** is the normal state. An instruction without a memory side effect, or one whose request is accepted at once, completes in the cycle it is presented.
- **OPEN_TO_HOLD**: a memory-triggering instruction meets a low `mem_req_ready`, and the controller moves to **ST_HOLD**.
- **ST_HOLD**: the request stays asserted and stable, and the instruction is not accepted.
- **HOLD_TO_OPEN**: `mem_req_ready` goes high. The request and the instruction are accepted together, and the controller returns to ST_OPEN.

Top module: `atls_unit`

## Requirements
- R1: After reset all registers read as zero, `wb_valid` is 0 and no memory request is driven while `ins_valid` is 0.
- R2: Short form: opcode in bits [29:24], i in [23:21], j in [20:18], k in [17:15]. Opcode 6'o10 gives Xi = Xj + Xk and 6'o11 gives Xi = Xj − Xk, both modulo 2^60. Opcode 6'o20 gives Bi = Bj + Bk and 6'o21 gives Bi = Bj − Bk, both modulo 2^18.
- R3: Long form: opcode [29:24], i [23:21], j [20:18], displacement [17:0]. Opcode 6'o30 gives Ai = Bj + disp, 6'o31 gives Bi = Bj + disp and 6'o32 gives Ai = Aj + disp, all modulo 2^18.
- R4: One cycle after an instruction is accepted, `wb_valid` is 1 with `wb_bank` (0 = data, 1 = address, 2 = index), `wb_idx` = i, and `wb_data` = the new value, zero-extended.
- R5: Accepting a write to A1–A5 issues exactly one read request. Its address is the low 17 bits of the new value and its tag is the index. A response with that tag writes `mem_rsp_data` into the data register of the same index.
- R6: Accepting a write to A6 or A7 issues one write request. `mem_req_wdata` is X6 or X7 as it stands at acceptance, the tag is the index, and the address is the low 17 bits of the new value.
- R7: Writing A0 updates A0 but issues no request. B0 always reads as zero, and a write to it changes nothing and raises no `wb_valid`.
- R8: While a read into Xn is outstanding, `ins_ready` stays 0 for any instruction that reads Xn, writes Xn, or writes An. This lasts up to and including the cycle the response arrives.
- R9: While a memory-triggering instruction sees `mem_req_ready` low, `ins_ready` is 0 and no register changes. The request keeps a stable address, tag and data until it is accepted.
- R10: An opcode outside the seven listed is accepted with no register write, no `wb_valid` and no request.
- R11: An accepted instruction write and a read response in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction word present |
| ins_word | input | 30 | Instruction word (short form uses bits 29:15) |
| ins_ready | output | 1 | Instruction accepted this cycle when valid |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 17 | Word address |
| mem_req_wdata | output | 60 | Write data |
| mem_req_tag | output | 3 | Index of the triggering address register |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_tag | input | 3 | Data register to fill |
| mem_rsp_data | input | 60 | Read data |
| wb_valid | output | 1 | A register was written on the last edge |
| wb_bank | output | 2 | Bank of that write |
| wb_idx | output | 3 | Index of that write |
| wb_data | output | 60 | Value written, zero-extended |

## Verification
The two functions that can fall in one cycle are an instruction's register write and a read response filling a different data register. The bench provokes this by issuing a read with a fixed three-cycle latency and then presenting a run of data adds that use only registers that are not pending. One of those adds is therefore accepted in the response cycle. A behavioural model compares the write-back port and every memory request each cycle. Later reads of both registers confirm that neither write was lost, and a counter confirms that the overlap actually occurred.

// File: rtl/atls_pkg.sv
package atls_pkg;
    localparam int NREG = 8;
    localparam int IW   = 3;
    localparam int AW   = 18;
    localparam int OPW  = 6;
    localparam int INSW = OPW + 2 * IW + AW;

    localparam logic [OPW-1:0] OPC_XADD = 6'o10;
    localparam logic [OPW-1:0] OPC_XSUB = 6'o11;
    localparam logic [OPW-1:0] OPC_BADD = 6'o20;
    localparam logic [OPW-1:0] OPC_BSUB = 6'o21;
    localparam logic [OPW-1:0] OPC_ASET = 6'o30;
    localparam logic [OPW-1:0] OPC_BSET = 6'o31;
    localparam logic [OPW-1:0] OPC_AADD = 6'o32;

    typedef enum logic [1:0] {
        BK_X    = 2'd0,
        BK_A    = 2'd1,
        BK_B    = 2'd2,
        BK_NONE = 2'd3
    } bank_e;

    typedef enum logic [2:0] {
        K_NOP, K_XADD, K_XSUB, K_BADD, K_BSUB, K_ASET, K_BSET, K_AADD
    } kind_e;

    typedef struct packed {
        kind_e           kind;
        bank_e           bank;
        logic [IW-1:0]   i;
        logic [IW-1:0]   j;
        logic [IW-1:0]   k;
        logic [AW-1:0]   disp;
        logic            rd_x;
    } dec_t;

    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_HOLD = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/atls_decode.sv
module atls_decode
    import atls_pkg::*;
(
    input  logic [INSW-1:0] ins_word,
    output dec_t            dec
);
    logic [OPW-1:0] op;

    assign op = ins_word[INSW-1 -: OPW];

    always_comb begin
        dec.kind = K_NOP;
        dec.bank = BK_NONE;
        dec.i    = ins_word[INSW-OPW-1 -: IW];
        dec.j    = ins_word[INSW-OPW-IW-1 -: IW];
        dec.k    = ins_word[INSW-OPW-2*IW-1 -: IW];
        dec.disp = ins_word[AW-1:0];
        dec.rd_x = 1'b0;
        unique case (op)
            OPC_XADD: begin dec.kind = K_XADD; dec.bank = BK_X; dec.rd_x = 1'b1; end
            OPC_XSUB: begin dec.kind = K_XSUB; dec.bank = BK_X; dec.rd_x = 1'b1; end
            OPC_BADD: begin dec.kind = K_BADD; dec.bank = BK_B; end
            OPC_BSUB: begin dec.kind = K_BSUB; dec.bank = BK_B; end
            OPC_ASET: begin dec.kind = K_ASET; dec.bank = BK_A; end
            OPC_BSET: begin dec.kind = K_BSET; dec.bank = BK_B; end
            OPC_AADD: begin dec.kind = K_AADD; dec.bank = BK_A; end
            default:  begin dec.kind = K_NOP;  dec.bank = BK_NONE; end
        endcase
    end
endmodule

// File: rtl/atls_regfile.sv
module atls_regfile
    import atls_pkg::*;
#(
    parameter int XW = 60
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [IW-1:0]  x_ra_idx,
    output logic [XW-1:0]  x_ra,
    input  logic [IW-1:0]  x_rb_idx,
    output logic [XW-1:0]  x_rb,
    input  logic [IW-1:0]  x_rc_idx,
    output logic [XW-1:0]  x_rc,
    input  logic [IW-1:0]  a_r_idx,
    output logic [AW-1:0]  a_r,
    input  logic [IW-1:0]  b_ra_idx,
    output logic [AW-1:0]  b_ra,
    input  logic [IW-1:0]  b_rb_idx,
    output logic [AW-1:0]  b_rb,
    input  logic           wr_en,
    input  bank_e          wr_bank,
    input  logic [IW-1:0]  wr_idx,
    input  logic [XW-1:0]  wr_data,
    input  logic           ld_en,
    input  logic [IW-1:0]  ld_idx,
    input  logic [XW-1:0]  ld_data
);
    logic [XW-1:0] xr [NREG];
    logic [AW-1:0] ar [NREG];
    logic [AW-1:0] br [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_x
        logic [XW-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (ld_en && ld_idx == IW'(g))
                q <= ld_data;
            else if (wr_en && wr_bank == BK_X && wr_idx == IW'(g))
                q <= wr_data;
        end
        assign xr[g] = q;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_a
        logic [AW-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && wr_bank == BK_A && wr_idx == IW'(g))
                q <= wr_data[AW-1:0];
        end
        assign ar[g] = q;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_b
        if (g == 0) begin : g_zero
            assign br[g] = '0;
        end else begin : g_reg
            logic [AW-1:0] q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_bank == BK_B && wr_idx == IW'(g))
                    q <= wr_data[AW-1:0];
            end
            assign br[g] = q;
        end
    end

    assign x_ra = xr[x_ra_idx];
    assign x_rb = xr[x_rb_idx];
    assign x_rc = xr[x_rc_idx];
    assign a_r  = ar[a_r_idx];
    assign b_ra = br[b_ra_idx];
    assign b_rb = br[b_rb_idx];
endmodule

// File: rtl/atls_pending.sv
module atls_pending
    import atls_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IW-1:0]   set_idx,
    input  logic            clr_en,
    input  logic [IW-1:0]   clr_idx,
    output logic [NREG-1:0] pend
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= '0;
        end else begin
            for (int n = 0; n < NREG; n++) begin
                if (set_en && set_idx == IW'(n))
                    pend[n] <= 1'b1;
                else if (clr_en && clr_idx == IW'(n))
                    pend[n] <= 1'b0;
            end
        end
    end

    // R5
    rsp_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> pend[clr_idx]);

    // R8
    no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_en |-> !pend[set_idx]);
endmodule

// File: rtl/atls_ctrl.sv
module atls_ctrl
    import atls_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ins_valid,
    input  logic need_mem,
    input  logic hazard,
    input  logic mem_ready,
    output logic ins_ready,
    output logic req_valid,
    output logic fire
);
    ctl_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_OPEN;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OPEN: if (req_valid && !mem_ready) state_nx = ST_HOLD;
            ST_HOLD: if (mem_ready || !ins_valid) state_nx = ST_OPEN;
        endcase
    end

    always_comb begin
        ins_ready = 1'b0;
        req_valid = 1'b0;
        unique case (state)
            ST_OPEN: begin
                req_valid = ins_valid && need_mem && !hazard;
                ins_ready = !hazard && (!need_mem || mem_ready);
            end
            ST_HOLD: begin
                req_valid = ins_valid && need_mem;
                ins_ready = mem_ready;
            end
        endcase
    end

    assign fire = ins_valid && ins_ready;

    // R9
    hold_keeps_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> req_valid);
endmodule

// File: rtl/atls_unit.sv
module atls_unit
    import atls_pkg::*;
#(
    parameter int XW     = 60,
    parameter int MEM_AW = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic [INSW-1:0]   ins_word,
    output logic              ins_ready,
    output logic              mem_req_valid,
    output logic              mem_req_write,
    output logic [MEM_AW-1:0] mem_req_addr,
    output logic [XW-1:0]     mem_req_wdata,
    output logic [IW-1:0]     mem_req_tag,
    input  logic              mem_req_ready,
    input  logic              mem_rsp_valid,
    input  logic [IW-1:0]     mem_rsp_tag,
    input  logic [XW-1:0]     mem_rsp_data,
    output logic              wb_valid,
    output logic [1:0]        wb_bank,
    output logic [IW-1:0]     wb_idx,
    output logic [XW-1:0]     wb_data
);
    dec_t            dec;
    logic [XW-1:0]   xj, xk, xi;
    logic [AW-1:0]   aj, bj, bk;
    logic [XW-1:0]   x_res, wr_data;
    logic [AW-1:0]   s_res;
    logic [NREG-1:0] pend;
    logic            need_mem, hazard, fire, wr_en;
    bank_e           wb_bank_q;

    atls_decode u_dec (.ins_word(ins_word), .dec(dec));

    atls_regfile #(.XW(XW)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .x_ra_idx(dec.j), .x_ra(xj),
        .x_rb_idx(dec.k), .x_rb(xk),
        .x_rc_idx(dec.i), .x_rc(xi),
        .a_r_idx(dec.j),  .a_r(aj),
        .b_ra_idx(dec.j), .b_ra(bj),
        .b_rb_idx(dec.k), .b_rb(bk),
        .wr_en(wr_en), .wr_bank(dec.bank), .wr_idx(dec.i), .wr_data(wr_data),
        .ld_en(mem_rsp_valid), .ld_idx(mem_rsp_tag), .ld_data(mem_rsp_data)
    );

    always_comb begin
        x_res = '0;
        s_res = '0;
        unique case (dec.kind)
            K_XADD:         x_res = xj + xk;
            K_XSUB:         x_res = xj - xk;
            K_BADD:         s_res = bj + bk;
            K_BSUB:         s_res = bj - bk;
            K_ASET, K_BSET: s_res = bj + dec.disp;
            K_AADD:         s_res = aj + dec.disp;
            default:        s_res = '0;
        endcase
    end

    assign wr_data  = (dec.bank == BK_X) ? x_res : XW'(s_res);
    assign need_mem = (dec.bank == BK_A) && (dec.i != '0);
    assign hazard   = (dec.rd_x && (pend[dec.j] || pend[dec.k]))
                   || (((dec.bank == BK_X) || (dec.bank == BK_A)) && pend[dec.i]);

    atls_ctrl u_ctl (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .need_mem(need_mem), .hazard(hazard),
        .mem_ready(mem_req_ready),
        .ins_ready(ins_ready), .req_valid(mem_req_valid), .fire(fire)
    );

    assign mem_req_write = &dec.i[IW-1:IW-2];
    assign mem_req_addr  = s_res[MEM_AW-1:0];
    assign mem_req_wdata = xi;
    assign mem_req_tag   = dec.i;
    assign wr_en         = fire && (dec.bank != BK_NONE);

    atls_pending u_pend (
        .clk(clk), .rst_n(rst_n),
        .set_en(fire && need_mem && !mem_req_write), .set_idx(dec.i),
        .clr_en(mem_rsp_valid), .clr_idx(mem_rsp_tag),
        .pend(pend)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid  <= 1'b0;
            wb_bank_q <= BK_X;
            wb_idx    <= '0;
            wb_data   <= '0;
        end else begin
            wb_valid  <= wr_en && !((dec.bank == BK_B) && (dec.i == '0));
            wb_bank_q <= dec.bank;
            wb_idx    <= dec.i;
            wb_data   <= wr_data;
        end
    end
    assign wb_bank = wb_bank_q;

    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_tag) && $stable(mem_req_wdata)));

    // R7
    a0_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && dec.bank == BK_A && dec.i == '0) |-> !mem_req_valid);

    // R6
    dir_by_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> ((mem_req_write == (mem_req_tag >= 3'd6)) && (mem_req_tag != '0)));

    // R4
    wb_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> ((wb_bank != BK_NONE) && !(wb_bank == BK_B && wb_idx == '0)));
endmodule

// File: tb/atls_unit_test.sv
module atls_unit_test;
    localparam int XW  = 60;
    localparam int MAW = 17;
    localparam logic [5:0] O_XADD = 6'o10, O_XSUB = 6'o11, O_BADD = 6'o20,
                           O_BSUB = 6'o21, O_ASET = 6'o30, O_BSET = 6'o31,
                           O_AADD = 6'o32, O_BAD = 6'o77;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, ins_valid, ins_ready, mem_req_valid, mem_req_write, mem_req_ready;
    logic [29:0] ins_word;
    logic [MAW-1:0] mem_req_addr;
    logic [XW-1:0] mem_req_wdata, mem_rsp_data, wb_data;
    logic [2:0] mem_req_tag, mem_rsp_tag, wb_idx;
    logic mem_rsp_valid, wb_valid;
    logic [1:0] wb_bank;

    atls_unit #(.XW(XW), .MEM_AW(MAW)) uut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_word(ins_word),
        .ins_ready(ins_ready), .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata), .mem_req_tag(mem_req_tag),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_tag(mem_rsp_tag),
        .mem_rsp_data(mem_rsp_data), .wb_valid(wb_valid), .wb_bank(wb_bank),
        .wb_idx(wb_idx), .wb_data(wb_data)
    );

    int checks = 0, failures = 0;
    bit done = 0;

    // reference state
    logic [XW-1:0] mx [8];
    logic [17:0]   ma [8];
    logic [17:0]   mb [8];
    bit            mp [8];
    logic [XW-1:0] mem [logic [MAW-1:0]];
    logic [29:0]   iq [$];
    int            rq_due [$];
    logic [2:0]    rq_tag [$];
    logic [XW-1:0] rq_data [$];
    bit            e_wbv = 0;
    logic [1:0]    e_wbb = 0;
    logic [2:0]    e_wbi = 0;
    logic [XW-1:0] e_wbd = 0;
    int cyc = 0, last_due = 0, lat = 4, rdy_mode = 0;
    bit gap_on = 0, held = 0, rand_lat = 0;
    int stall_cnt = 0, hold_cnt = 0, both_cnt = 0, req_hs = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [29:0] enc_s(logic [5:0] op, int i, int j, int k);
        return {op, 3'(i), 3'(j), 3'(k), 15'd0};
    endfunction

    function automatic logic [29:0] enc_l(logic [5:0] op, int i, int j, int d);
        return {op, 3'(i), 3'(j), 18'(d)};
    endfunction

    function automatic logic [XW-1:0] mem_rd(logic [MAW-1:0] a);
        if (mem.exists(a)) return mem[a];
        return {3'b101, a, ~a, 23'h2a5a5};
    endfunction

    task automatic cycle();
        bit iv, haz, mem_op, xop, aop, known, e_rdy, e_rv, e_wr, acc, d_hs, rv;
        logic [5:0] op;
        logic [2:0] i, j, k, rt;
        logic [17:0] disp, sres;
        logic [XW-1:0] xres, rd;
        logic [1:0] bank;
        iv = (iq.size() > 0);
        if (iv && gap_on && !held && ($urandom % 4 == 0)) iv = 0;
        ins_valid = iv;
        ins_word  = (iq.size() > 0) ? iq[0] : 30'h0;
        case (rdy_mode)
            0: mem_req_ready = 1'b1;
            1: mem_req_ready = (cyc % 3) != 0;
            default: mem_req_ready = ($urandom % 3) != 0;
        endcase
        rv = (rq_due.size() > 0) && (rq_due[0] <= cyc);
        mem_rsp_valid = rv;
        mem_rsp_tag   = rv ? rq_tag[0] : 3'd0;
        mem_rsp_data  = rv ? rq_data[0] : '0;
        #3;
        op = ins_word[29:24]; i = ins_word[23:21]; j = ins_word[20:18];
        k = ins_word[17:15]; disp = ins_word[17:0];
        xres = '0; sres = '0; known = 1; bank = 2'd3;
        case (op)
            O_XADD: begin xres = mx[j] + mx[k]; bank = 0; end
            O_XSUB: begin xres = mx[j] - mx[k]; bank = 0; end
            O_BADD: begin sres = mb[j] + mb[k]; bank = 2; end
            O_BSUB: begin sres = mb[j] - mb[k]; bank = 2; end
            O_ASET: begin sres = mb[j] + disp; bank = 1; end
            O_BSET: begin sres = mb[j] + disp; bank = 2; end
            O_AADD: begin sres = ma[j] + disp; bank = 1; end
            default: known = 0;
        endcase
        xop = (op == O_XADD) || (op == O_XSUB);
        aop = (op == O_ASET) || (op == O_AADD);
        haz = (xop && (mp[j] || mp[k] || mp[i])) || (aop && mp[i]);
        mem_op = aop && (i != 0);
        e_wr  = (i >= 6);
        e_rdy = !haz && (!mem_op || mem_req_ready);
        e_rv  = iv && mem_op && !haz;
        if (iv) chk(ins_ready == e_rdy, "R8 R9 ins_ready", 64'(ins_ready), 64'(e_rdy));
        chk(mem_req_valid == e_rv, "R5 R6 R7 R9 mem_req_valid", 64'(mem_req_valid), 64'(e_rv));
        if (e_rv) begin
            chk(mem_req_write == e_wr, "R5 R6 direction", 64'(mem_req_write), 64'(e_wr));
            chk(mem_req_addr == sres[MAW-1:0], "R5 R6 address", 64'(mem_req_addr), 64'(sres[MAW-1:0]));
            chk(mem_req_tag == i, "R5 R6 tag", 64'(mem_req_tag), 64'(i));
            if (e_wr) chk(mem_req_wdata == mx[i], "R6 store data", 64'(mem_req_wdata), 64'(mx[i]));
        end
        chk(wb_valid == e_wbv, "R4 R7 R10 wb_valid", 64'(wb_valid), 64'(e_wbv));
        if (e_wbv) begin
            chk(wb_bank == e_wbb, "R4 wb_bank", 64'(wb_bank), 64'(e_wbb));
            chk(wb_idx == e_wbi, "R4 wb_idx", 64'(wb_idx), 64'(e_wbi));
            chk(wb_data == e_wbd, "R2 R3 R4 wb_data", 64'(wb_data), 64'(e_wbd));
        end
        acc  = iv && e_rdy;
        d_hs = mem_req_valid && mem_req_ready;
        if (iv && haz) stall_cnt++;
        if (e_rv && !mem_req_ready) hold_cnt++;
        if (acc && known && rv) both_cnt++;
        held = iv && !e_rdy;
        rt = mem_rsp_tag; rd = mem_rsp_data;
        @(posedge clk);
        e_wbv = 0;
        if (acc) begin
            if (mem_op) begin
                if (e_wr) mem[sres[MAW-1:0]] = mx[i];
                else begin
                    mp[i] = 1;
                    if (rand_lat) lat = 1 + int'($urandom % 6);
                    last_due = (cyc + lat > last_due + 1) ? cyc + lat : last_due + 1;
                    rq_due.push_back(last_due);
                    rq_tag.push_back(i);
                    rq_data.push_back(mem_rd(sres[MAW-1:0]));
                end
            end
            case (bank)
                2'd0: begin mx[i] = xres; e_wbv = 1; e_wbd = xres; end
                2'd1: begin ma[i] = sres; e_wbv = 1; e_wbd = XW'(sres); end
                2'd2: if (i != 0) begin mb[i] = sres; e_wbv = 1; e_wbd = XW'(sres); end
                default: ;
            endcase
            e_wbb = bank; e_wbi = i;
            void'(iq.pop_front());
        end
        if (rv) begin
            mx[rt] = rd; mp[rt] = 0;
            void'(rq_due.pop_front()); void'(rq_tag.pop_front()); void'(rq_data.pop_front());
        end
        if (d_hs) req_hs++;
        cyc++;
        #1;
    endtask

    task automatic drain();
        int n = 0;
        while ((iq.size() > 0 || rq_due.size() > 0) && n < 3000) begin
            cycle();
            n++;
        end
        chk(n < 3000, "R8 drain completes", 64'(n), 64'(3000));
    endtask

    initial begin
        automatic logic [5:0] ops [8] = '{O_XADD, O_XSUB, O_BADD, O_BSUB, O_ASET, O_BSET, O_AADD, O_BAD};
        int h0;
        for (int n = 0; n < 8; n++) begin mx[n] = '0; ma[n] = '0; mb[n] = '0; mp[n] = 0; end
        rst_n = 0; ins_valid = 0; ins_word = '0; mem_req_ready = 1;
        mem_rsp_valid = 0; mem_rsp_tag = '0; mem_rsp_data = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        #3;
        // R1 reset state
        chk(wb_valid == 0, "R1 wb_valid after reset", 64'(wb_valid), 64'(0));
        chk(mem_req_valid == 0, "R1 no request after reset", 64'(mem_req_valid), 64'(0));
        @(posedge clk); #1;
        iq.push_back(enc_s(O_XADD, 0, 1, 2));           // R1 registers read zero
        drain();
        // R2 R3 R7 index arithmetic and B0
        iq.push_back(enc_l(O_BSET, 1, 0, 100));
        iq.push_back(enc_l(O_BSET, 2, 0, 18'h3FFFF));
        iq.push_back(enc_s(O_BADD, 3, 1, 2));
        iq.push_back(enc_s(O_BSUB, 4, 2, 1));
        iq.push_back(enc_l(O_BSET, 0, 1, 5));
        iq.push_back(enc_s(O_BADD, 5, 0, 1));
        drain();
        // R5 R8 loads and stall
        lat = 4;
        iq.push_back(enc_l(O_ASET, 1, 1, 0));
        iq.push_back(enc_l(O_ASET, 2, 0, 200));
        iq.push_back(enc_s(O_XADD, 3, 1, 2));
        iq.push_back(enc_s(O_XSUB, 4, 3, 1));
        drain();
        chk(stall_cnt > 0, "R8 hazard stall seen", 64'(stall_cnt), 64'(1));
        // R6 store captures data at acceptance
        h0 = req_hs;
        iq.push_back(enc_s(O_XADD, 6, 3, 4));
        iq.push_back(enc_l(O_ASET, 6, 0, 300));
        iq.push_back(enc_s(O_XADD, 6, 6, 6));
        iq.push_back(enc_l(O_ASET, 5, 0, 300));
        iq.push_back(enc_s(O_XADD, 0, 5, 0));
        iq.push_back(enc_l(O_AADD, 7, 6, 1));
        drain();
        chk(req_hs == h0 + 3, "R5 R6 request count", 64'(req_hs), 64'(h0 + 3));
        // R7 R10 no request for A0 or unknown opcode
        h0 = req_hs;
        iq.push_back(enc_l(O_ASET, 0, 1, 7));
        iq.push_back(enc_l(O_BAD, 3, 1, 2));
        iq.push_back(enc_s(O_XSUB, 1, 0, 6));
        drain();
        chk(req_hs == h0, "R7 R10 no request", 64'(req_hs), 64'(h0));
        // R9 memory back-pressure
        rdy_mode = 1;
        iq.push_back(enc_l(O_ASET, 6, 0, 400));
        iq.push_back(enc_l(O_ASET, 3, 0, 410));
        iq.push_back(enc_l(O_ASET, 7, 2, 5));
        iq.push_back(enc_l(O_AADD, 4, 3, 2));
        drain();
        chk(hold_cnt > 0, "R9 hold seen", 64'(hold_cnt), 64'(1));
        rdy_mode = 0;
        // R11 response and instruction write in the same cycle
        both_cnt = 0; lat = 3;
        iq.push_back(enc_l(O_ASET, 3, 1, 20));
        for (int n = 0; n < 6; n++) iq.push_back(enc_s(O_XADD, 7, 0, 6));
        iq.push_back(enc_s(O_XSUB, 2, 3, 7));
        drain();
        chk(both_cnt > 0, "R11 overlap provoked", 64'(both_cnt), 64'(1));
        // random mix
        rdy_mode = 2; gap_on = 1; rand_lat = 1;
        for (int n = 0; n < 400; n++) begin
            automatic logic [5:0] op = ops[$urandom % 8];
            if (op == O_ASET || op == O_BSET || op == O_AADD)
                iq.push_back(enc_l(op, int'($urandom % 8), int'($urandom % 8), int'($urandom % 1024)));
            else
                iq.push_back(enc_s(op, int'($urandom % 8), int'($urandom % 8), int'($urandom % 8)));
        end
        drain();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R8 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule